// File: doc/BRIEF.md
# Windowed Start/Stop Measurement Counter

This block measures how long, or how often, something happens between a start pulse and a later stop pulse. An accepted start opens a measurement window and an accepted stop closes it. While the window is open, a counter advances on a selectable source: a timing tick enable, the closing stop pulse itself (so that windows are counted), a separate event pulse, or every clock cycle. A configuration bit chooses whether each new window restarts the counter from zero or continues from the previous total.

When a window closes, the result is either folded into a saved register (kept as the last, smallest or largest result since the last clear) or compared against a limit. In limit mode the comparison happens only at the stop, and a failing result sets a sticky violation flag. A counter wrap sets a sticky overflow flag. Each flag can raise a one-cycle break request, but only in the cycle where that flag goes from clear to set. A clear input returns the counter, saved value and flags to zero before a new series of measurements.

Top module: `meas_counter_unit`

## Requirements
- R1: Reset (rst_n low) or a clear cycle (clr high) leaves count_o, saved_o, ovf_flag_o, thr_flag_o and brk_o at zero and the window closed on the following cycle; clr overrides every other input.
- R2: The counter moves only while a window is open. The edge that accepts a start does not count, and the edge that accepts a stop does count when the source fires then. With no open window, count_o holds its value.
- R3: A start that arrives while a window is open is ignored and does not reset the count. A stop with no open window is ignored: it neither updates saved_o nor makes a limit check.
- R4: With cfg_accum = 0, an accepted start zeroes the counter. With cfg_accum = 1, the counter keeps its value and successive windows add up.
- R5: cfg_src picks the count source: 0 = tick_i, 1 = the stop pulse that closes the window, 2 = event_i, 3 = every clock cycle.
- R6: cfg_save selects 0 = last, 1 = minimum, 2 = maximum. At each accepted stop, saved_o takes the final window result in last mode. In minimum or maximum mode, the first window after a clear loads saved_o unconditionally, and later windows update it only when the result is strictly smaller or larger.
- R7: cfg_save = 3 is limit mode. At each accepted stop, saved_o latches cfg_limit. The result violates the limit when it is above cfg_limit (cfg_limit_is_max = 1) or below cfg_limit (cfg_limit_is_max = 0), and a violation sets thr_flag_o, which stays set until clear.
- R8: The counter is CNT_W bits wide (32 by default). An increment from all ones wraps it to zero and sets ovf_flag_o, which stays set until clear.
- R9: brk_o is high for exactly one cycle, the first cycle in which an enabled flag reads set after having been clear (cfg_brk_ovf for overflow, cfg_brk_thr for the limit). A flag that is already set raises no further request.
- R10: All outputs are registered. The effect of inputs sampled at a clock edge appears on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clears counter, saved value, flags and window |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| tick_i | input | 1 | Timing tick enable |
| event_i | input | 1 | External event pulse |
| cfg_src | input | 2 | Count source select |
| cfg_accum | input | 1 | 1 = accumulate across windows |
| cfg_save | input | 2 | Save mode: last, min, max, limit |
| cfg_limit_is_max | input | 1 | 1 = limit is the largest allowed count |
| cfg_limit | input | CNT_W | Limit value |
| cfg_brk_ovf | input | 1 | Break enable for overflow |
| cfg_brk_thr | input | 1 | Break enable for limit violation |
| count_o | output | CNT_W | Current counter value |
| saved_o | output | CNT_W | Saved result or latched limit |
| thr_flag_o | output | 1 | Sticky limit-violation flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| brk_o | output | 1 | One-cycle break request |

## Verification
Two things can fall in one cycle: the closing stop can also be the last increment, and a start can arrive together with a stop. The bench therefore checks that the saved result includes the count taken on the stop edge, and that a start arriving inside an open window leaves the count intact. Overflow and the limit check can also land on the same stop edge. The bench provokes this with an 8-bit counter and windows exactly one cycle shorter than, equal to, and past the wrap point. It judges each case from arithmetic totals of the counted cycles and from whether brk_o pulses once, only on a fresh flag.

// File: rtl/meas_pkg.sv
// Package: shared encodings for the measurement counter unit.
// Assumes: two-bit configuration fields driven directly by software.
package meas_pkg;
    typedef enum logic [1:0] {
        SRC_TICK  = 2'd0,
        SRC_STOP  = 2'd1,
        SRC_EVENT = 2'd2,
        SRC_CYCLE = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        SAVE_LAST  = 2'd0,
        SAVE_MIN   = 2'd1,
        SAVE_MAX   = 2'd2,
        SAVE_LIMIT = 2'd3
    } save_mode_e;
endpackage

// File: rtl/meas_window_ctrl.sv
// Module: tracks whether a measurement window is open and qualifies start/stop.
// Assumes: start/stop are single-cycle pulses; clr closes any open window.
module meas_window_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start_i,
    input  logic stop_i,
    output logic open_o,
    output logic start_acc_o,
    output logic stop_acc_o
);
    logic open_q;

    // Qualify pulses: start only when closed, stop only when open.
    always_comb begin
        start_acc_o = start_i && !open_q && !clr;
        stop_acc_o  = stop_i  &&  open_q && !clr;
    end

    // Window state register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     open_q <= 1'b0;
        else if (start_acc_o)  open_q <= 1'b1;
        else if (stop_acc_o)   open_q <= 1'b0;
    end

    assign open_o = open_q;

    assert_stop_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && open_o && !clr) |=> !open_o);
    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !open_o && !clr) |=> open_o);
    assert_open_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && start_i && !stop_i && !clr) |=> open_o);
endmodule

// File: rtl/meas_counter.sv
// Module: the measurement counter with selectable source and wrap detection.
// Assumes: open_i and start_acc_i are never high together.
module meas_counter
    import meas_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             open_i,
    input  logic             start_acc_i,
    input  logic             accum_i,
    input  logic [1:0]       src_i,
    input  logic             tick_i,
    input  logic             stop_i,
    input  logic             event_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             inc;

    // Source multiplexer.
    always_comb begin
        case (src_sel_e'(src_i))
            SRC_TICK:  hit = tick_i;
            SRC_STOP:  hit = stop_i;
            SRC_EVENT: hit = event_i;
            default:   hit = 1'b1;
        endcase
    end

    // Next counter value and wrap detection.
    always_comb begin
        inc    = open_i && hit && !clr;
        wrap_o = inc && (&cnt_q);
        if (clr)              cnt_next_o = '0;
        else if (start_acc_i) cnt_next_o = accum_i ? cnt_q : '0;
        else if (inc)         cnt_next_o = cnt_q + CNT_ONE;
        else                  cnt_next_o = cnt_q;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next_o;
    end

    assign cnt_o = cnt_q;

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_o == '0));
    assert_closed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_i && !start_acc_i && !clr) |=> (cnt_o == $past(cnt_o)));
    assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));
endmodule

// File: rtl/meas_capture.sv
// Module: end-of-window capture (last/min/max) or limit check.
// Assumes: stop_acc_i is high only on the edge that closes a window;
//          result_i already includes the count taken on that edge.
module meas_capture
    import meas_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stop_acc_i,
    input  logic [CNT_W-1:0] result_i,
    input  logic [1:0]       mode_i,
    input  logic             limit_is_max_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] saved_o,
    output logic             viol_o
);
    logic [CNT_W-1:0] saved_q;
    logic             valid_q;
    logic             take;
    save_mode_e       mode;

    // Decide whether the current stop updates the saved register.
    always_comb begin
        mode = save_mode_e'(mode_i);
        case (mode)
            SAVE_MIN: take = !valid_q || (result_i < saved_q);
            SAVE_MAX: take = !valid_q || (result_i > saved_q);
            default:  take = 1'b1;
        endcase
    end

    // Limit comparison, meaningful only on an accepted stop in limit mode.
    always_comb begin
        viol_o = stop_acc_i && (mode == SAVE_LIMIT) &&
                 (limit_is_max_i ? (result_i > limit_i) : (result_i < limit_i));
    end

    // Saved value and first-window marker.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            saved_q <= '0;
            valid_q <= 1'b0;
        end else if (stop_acc_i) begin
            valid_q <= 1'b1;
            if (mode == SAVE_LIMIT) saved_q <= limit_i;
            else if (take)          saved_q <= result_i;
        end
    end

    assign saved_o = saved_q;

    assert_min_never_rises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && stop_acc_i && !clr && mode == SAVE_MIN) |=> (saved_o <= $past(saved_o)));
    assert_max_never_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && stop_acc_i && !clr && mode == SAVE_MAX) |=> (saved_o >= $past(saved_o)));
    assert_no_stop_no_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_acc_i && !clr) |=> $stable(saved_o));
endmodule

// File: rtl/meas_flag_break.sv
// Module: sticky overflow / limit-violation flags and rising-edge break pulse.
// Assumes: wrap_i and viol_i are single-cycle qualifiers from the datapath.
module meas_flag_break (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wrap_i,
    input  logic viol_i,
    input  logic brk_ovf_en_i,
    input  logic brk_thr_en_i,
    output logic ovf_o,
    output logic thr_o,
    output logic brk_o
);
    logic ovf_q, thr_q, brk_q;
    logic ovf_new, thr_new;

    // A flag is "new" only when it sets from a clear state.
    always_comb begin
        ovf_new = wrap_i && !ovf_q;
        thr_new = viol_i && !thr_q;
    end

    // Sticky flags and registered break request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ovf_q <= 1'b0;
            thr_q <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            ovf_q <= ovf_q | wrap_i;
            thr_q <= thr_q | viol_i;
            brk_q <= (ovf_new && brk_ovf_en_i) || (thr_new && brk_thr_en_i);
        end
    end

    assign ovf_o = ovf_q;
    assign thr_o = thr_q;
    assign brk_o = brk_q;

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr) |=> ovf_o);
    assert_thr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_o && !clr) |=> thr_o);
    assert_brk_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> ((ovf_o && !$past(ovf_o)) || (thr_o && !$past(thr_o))));
    assert_brk_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |=> !brk_o);
endmodule

// File: rtl/meas_counter_unit.sv
// Module: top of the windowed start/stop measurement counter.
// Assumes: all inputs synchronous to clk; configuration stable during a window.
module meas_counter_unit #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic             event_i,
    input  logic [1:0]       cfg_src,
    input  logic             cfg_accum,
    input  logic [1:0]       cfg_save,
    input  logic             cfg_limit_is_max,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic             cfg_brk_ovf,
    input  logic             cfg_brk_thr,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] saved_o,
    output logic             thr_flag_o,
    output logic             ovf_flag_o,
    output logic             brk_o
);
    logic             win_open, start_acc, stop_acc;
    logic [CNT_W-1:0] cnt_next;
    logic             wrap, viol;

    meas_window_ctrl u_win (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .start_i(start_i), .stop_i(stop_i),
        .open_o(win_open), .start_acc_o(start_acc), .stop_acc_o(stop_acc)
    );

    meas_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .open_i(win_open), .start_acc_i(start_acc), .accum_i(cfg_accum),
        .src_i(cfg_src), .tick_i(tick_i), .stop_i(stop_i), .event_i(event_i),
        .cnt_o(count_o), .cnt_next_o(cnt_next), .wrap_o(wrap)
    );

    meas_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .stop_acc_i(stop_acc), .result_i(cnt_next),
        .mode_i(cfg_save), .limit_is_max_i(cfg_limit_is_max), .limit_i(cfg_limit),
        .saved_o(saved_o), .viol_o(viol)
    );

    meas_flag_break u_flg (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wrap_i(wrap), .viol_i(viol),
        .brk_ovf_en_i(cfg_brk_ovf), .brk_thr_en_i(cfg_brk_thr),
        .ovf_o(ovf_flag_o), .thr_o(thr_flag_o), .brk_o(brk_o)
    );

    assert_clear_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (saved_o == '0 && !thr_flag_o && !ovf_flag_o && !brk_o));
endmodule

// File: tb/tb_meas_counter_unit.sv
`timescale 1ns/1ps
// Bench: sweeps window lengths, sources and save modes on an 8-bit counter.
module tb_meas_counter_unit;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, start_i = 1'b0, stop_i = 1'b0, tick_i = 1'b0, event_i = 1'b0;
    logic [1:0] cfg_src = 2'd3, cfg_save = 2'd0;
    logic cfg_accum = 1'b0, cfg_limit_is_max = 1'b1, cfg_brk_ovf = 1'b0, cfg_brk_thr = 1'b0;
    logic [W-1:0] cfg_limit = '0;
    logic [W-1:0] count_o, saved_o;
    logic thr_flag_o, ovf_flag_o, brk_o;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    meas_counter_unit #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start_i(start_i), .stop_i(stop_i),
        .tick_i(tick_i), .event_i(event_i), .cfg_src(cfg_src), .cfg_accum(cfg_accum),
        .cfg_save(cfg_save), .cfg_limit_is_max(cfg_limit_is_max), .cfg_limit(cfg_limit),
        .cfg_brk_ovf(cfg_brk_ovf), .cfg_brk_thr(cfg_brk_thr),
        .count_o(count_o), .saved_o(saved_o), .thr_flag_o(thr_flag_o),
        .ovf_flag_o(ovf_flag_o), .brk_o(brk_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    // Open a window, k counted edges, the last one being the stop edge.
    task automatic window(input int k);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (k-1) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    // Window of k edges; tick follows pat, event follows its complement.
    task automatic window_pat(input int k, input logic [15:0] pat);
        @(negedge clk) begin start_i = 1'b1; tick_i = 1'b1; event_i = 1'b1; end
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            tick_i  = pat[i];
            event_i = ~pat[i];
            stop_i  = (i == k-1);
        end
        @(negedge clk) begin stop_i = 1'b0; tick_i = 1'b0; event_i = 1'b0; end
    endtask

    initial begin
        #(200000 * 8);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int lens[4] = '{5, 3, 9, 2};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 count after reset", count_o, 0);
        check("R1 saved after reset", saved_o, 0);
        check("R1 flags after reset", {thr_flag_o, ovf_flag_o, brk_o}, 0);

        // R6 / R2 / R10: sweep save modes over a sequence of window lengths.
        for (int m = 0; m < 3; m++) begin
            int expv;
            cfg_save = 2'(m); cfg_src = 2'd3; cfg_accum = 1'b0;
            do_clear();
            for (int j = 0; j < 4; j++) begin
                window(lens[j]);
                if (j == 0)      expv = lens[j];
                else if (m == 0) expv = lens[j];
                else if (m == 1) expv = (lens[j] < expv) ? lens[j] : expv;
                else             expv = (lens[j] > expv) ? lens[j] : expv;
                check("R2 count equals window length", count_o, lens[j]);
                check("R6 saved after window", saved_o, expv);
            end
            repeat (3) @(negedge clk);
            check("R2 count holds while closed", count_o, lens[3]);
        end

        // R1: clear resets count and saved
        do_clear();
        check("R1 count after clear", count_o, 0);
        check("R1 saved after clear", saved_o, 0);

        // R4: accumulate across windows vs restart
        cfg_save = 2'd0; cfg_accum = 1'b1;
        window(3); window(4);
        check("R4 accumulated count", count_o, 7);
        cfg_accum = 1'b0;
        window(2);
        check("R4 restart count", count_o, 2);

        // R3: start inside an open window is ignored
        do_clear();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (2) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        check("R3 start ignored while open", count_o, 7);

        // R5: source select with tick pattern vs complemented event pattern
        for (int p = 0; p < 4; p++) begin
            logic [15:0] pat;
            int k;
            pat = 16'hA5C3 ^ 16'(p * 16'h1357);
            k = 6 + p;
            cfg_src = 2'd0;
            window_pat(k, pat);
            check("R5 tick source count", count_o, $countones(pat & 16'((1 << k) - 1)));
            cfg_src = 2'd2;
            window_pat(k, pat);
            check("R5 event source count", count_o, $countones(~pat & 16'((1 << k) - 1)));
        end
        // R5: stop pulses as source, accumulated over three windows
        do_clear();
        cfg_src = 2'd1; cfg_accum = 1'b1;
        window(4); window(2); window(5);
        check("R5 stop source counts windows", count_o, 3);
        cfg_accum = 1'b0;

        // R7 / R9: limit sweep, both polarities
        cfg_src = 2'd3; cfg_save = 2'd3; cfg_limit = 8'd5; cfg_brk_thr = 1'b1;
        for (int pol = 0; pol < 2; pol++) begin
            for (int len = 1; len <= 8; len++) begin
                logic ev;
                cfg_limit_is_max = pol[0];
                ev = pol[0] ? (len > 5) : (len < 5);
                do_clear();
                window(len);
                check("R7 violation flag", thr_flag_o, ev);
                check("R9 break on fresh violation", brk_o, ev);
                check("R7 saved holds limit", saved_o, 5);
                @(negedge clk);
                check("R9 break lasts one cycle", brk_o, 0);
            end
        end
        // R9: no second break while flag already set; R7 sticky
        cfg_limit_is_max = 1'b1;
        window(9);
        check("R9 no break when flag already set", brk_o, 0);
        window(2);
        check("R7 flag sticky after passing window", thr_flag_o, 1);

        // R3: stop with no open window makes no check and no save
        do_clear();
        window(3);
        cfg_limit = 8'd1;
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        check("R3 stray stop no limit check", thr_flag_o, 0);
        check("R3 stray stop no save", saved_o, 5);

        // R8: wrap boundaries on the 8-bit counter
        cfg_save = 2'd0; cfg_brk_thr = 1'b0; cfg_brk_ovf = 1'b1;
        do_clear();
        window(255);
        check("R8 no overflow at all ones", ovf_flag_o, 0);
        check("R8 count at all ones", count_o, 255);
        do_clear();
        window(256);
        check("R8 wrap count", count_o, 0);
        check("R8 overflow flag", ovf_flag_o, 1);
        check("R9 break on overflow", brk_o, 1);
        @(negedge clk);
        check("R9 overflow break one cycle", brk_o, 0);
        window(256);
        check("R8 overflow sticky", ovf_flag_o, 1);
        check("R9 no repeat overflow break", brk_o, 0);
        cfg_brk_ovf = 1'b0;
        do_clear();
        window(257);
        check("R8 wrap past zero", count_o, 1);
        check("R9 break disabled", brk_o, 0);

        // R1: clear overrides a start in the same cycle
        @(negedge clk) begin clr = 1'b1; start_i = 1'b1; end
        @(negedge clk) begin clr = 1'b0; start_i = 1'b0; end
        repeat (2) @(negedge clk);
        check("R1 clear beats start", count_o, 0);
        check("R1 flags cleared", {thr_flag_o, ovf_flag_o}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule